// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every cycle, which hardware threads the instruction fetch stage may serve. It looks at each thread's 3-bit fetch state and its active bit. Under the two queue-based policies it also looks at per-thread occupancy counts. It then fills a fixed number of grant slots, each carrying a valid flag and a thread index. Slot 0 is the first choice. The later slots are further choices for a fetch stage that serves several threads in one cycle. A thread never appears in two slots of the same cycle.

The policy comes from a 2-bit configuration input:
- `0` is single-thread.
- `1` is round-robin.
- `2` ranks threads by issue-queue occupancy.
- `3` ranks threads by load/store-queue occupancy.

Round-robin keeps a registered priority list of thread indices. Each thread granted under round-robin leaves its place in the list and joins the tail. The occupancy counts are computed elsewhere, and the fetch that follows a grant is also outside this block. The grant outputs are combinational from the inputs and the priority list. Only the list is updated at the clock edge.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread can be granted only if its active bit is 1 and its state code is one of three values: 0 (running), 1 (idle) or 5 (instruction-cache access done). The codes 2, 3, 4, 6 and 7 make a thread ineligible.
- R2: With more than one thread configured and policy code 0, slot 0 is valid with thread 0, whatever the states and active bits are. All other slots are invalid.
- R3: With policy code 1, slot k grants the first eligible thread, counted from the head of the priority list, that no lower slot has granted in the same cycle.
- R4: At each clock edge under policy code 1, every thread granted in that cycle is taken out of the priority list and appended at its tail, in slot order. Under any other policy, the list keeps its order.
- R5: Reset (rst_ni low, asynchronous) sets the priority list to 0, 1, 2, ... from head to tail.
- R6: Under policy code 2 (issue-queue counts) or 3 (load/store-queue counts), slot k grants the eligible thread not yet granted in that cycle with the smallest count. On equal counts, the lower thread index wins.
- R7: No thread index is granted in two valid slots of the same cycle.
- R8: When no eligible thread remains for a slot, that slot and every higher slot are invalid.
- R9: With one thread configured, slot 0 is valid with thread 0 exactly when thread 0 is eligible under R1, for every policy code. The other slots are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Selection policy code |
| thr_state_i | input | NUM_THREADS*3 | Fetch state code per thread; thread t in bits [3t+2:3t] |
| thr_active_i | input | NUM_THREADS | Active-thread mask |
| iq_cnt_i | input | NUM_THREADS*CNT_W | Issue-queue occupancy per thread |
| lsq_cnt_i | input | NUM_THREADS*CNT_W | Load/store-queue occupancy per thread |
| grant_vld_o | output | SLOTS | Valid flag per grant slot |
| grant_tid_o | output | SLOTS*TID_W | Thread index per grant slot |

## Verification
The bench keeps an independent model of the priority list and follows it through a mixed sequence of policies. A design that rotated the list under the single-thread or occupancy policies would give a different round-robin order afterwards. A design that moved only the slot-0 winner to the tail would also diverge. Equal occupancy counts are applied on purpose; a selector that let the higher index win the tie, or that granted the same thread in both slots, fails those checks. Ineligible state codes and cleared active bits are mixed with eligible ones to catch a wrong eligibility set. A one-thread instance confirms that the policy code has no effect there.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQUASH   = 3'd2,
    ST_BLOCK    = 3'd3,
    ST_IC_WAIT  = 3'd4,
    ST_IC_DONE  = 3'd5,
    ST_QUIESCE  = 3'd6,
    ST_TRAP     = 3'd7
  } fetch_st_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_RR     = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } sel_pol_e;

  function automatic logic st_fetchable(logic [ST_W-1:0] st);
    return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_IC_DONE);
  endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*ST_W-1:0] state_i,
  input  logic [N-1:0]      active_i,
  output logic [N-1:0]      elig_o
);

  for (genvar t = 0; t < N; t++) begin : g_thr
    assign elig_o[t] = active_i[t] && st_fetchable(state_i[t*ST_W +: ST_W]);
  end

endmodule

// File: rtl/fsel_rr.sv
module fsel_rr #(
  parameter int N     = 4,
  parameter int SLOTS = 2,
  parameter int TID_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_en_i,
  input  logic [N-1:0]       elig_i,
  output logic [SLOTS-1:0]   pick_vld_o,
  output logic [SLOTS*TID_W-1:0] pick_tid_o
);

  localparam int NP = 1 << TID_W;

  logic [TID_W-1:0] order_q [N];
  logic [TID_W-1:0] order_d [N];
  logic [NP-1:0]    elig_x;

  always_comb begin
    elig_x = '0;
    elig_x[N-1:0] = elig_i;
  end

  // Sequential scan per slot; each winner is rotated to the tail before the next slot scans.
  always_comb begin
    logic [NP-1:0]    taken;
    logic [TID_W-1:0] lst [N];
    logic [TID_W-1:0] win;
    logic             hit;
    int               pos;
    taken      = '0;
    pick_vld_o = '0;
    pick_tid_o = '0;
    for (int p = 0; p < N; p++) lst[p] = order_q[p];
    for (int k = 0; k < SLOTS; k++) begin
      hit = 1'b0;
      win = '0;
      pos = 0;
      for (int p = 0; p < N; p++) begin
        if (!hit && elig_x[lst[p]] && !taken[lst[p]]) begin
          hit = 1'b1;
          win = lst[p];
          pos = p;
        end
      end
      if (hit) begin
        taken[win] = 1'b1;
        pick_vld_o[k] = 1'b1;
        pick_tid_o[k*TID_W +: TID_W] = win;
        for (int p = 0; p < N - 1; p++) begin
          if (p >= pos) lst[p] = lst[p+1];
        end
        lst[N-1] = win;
      end
    end
    for (int p = 0; p < N; p++) order_d[p] = lst[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N; p++) order_q[p] <= TID_W'(p);
    end else if (upd_en_i) begin
      for (int p = 0; p < N; p++) order_q[p] <= order_d[p];
    end
  end

endmodule

// File: rtl/fsel_occ.sv
module fsel_occ #(
  parameter int N     = 4,
  parameter int SLOTS = 2,
  parameter int CNT_W = 6,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]           elig_i,
  input  logic [N*CNT_W-1:0]     cnt_i,
  output logic [SLOTS-1:0]       pick_vld_o,
  output logic [SLOTS*TID_W-1:0] pick_tid_o
);

  always_comb begin
    logic [N-1:0]     taken;
    logic             hit;
    logic [CNT_W-1:0] best_cnt;
    int               best;
    taken      = '0;
    pick_vld_o = '0;
    pick_tid_o = '0;
    for (int k = 0; k < SLOTS; k++) begin
      hit      = 1'b0;
      best     = 0;
      best_cnt = '0;
      // strict less-than keeps the lower index on equal counts
      for (int j = 0; j < N; j++) begin
        if (elig_i[j] && !taken[j] &&
            (!hit || (cnt_i[j*CNT_W +: CNT_W] < best_cnt))) begin
          hit      = 1'b1;
          best     = j;
          best_cnt = cnt_i[j*CNT_W +: CNT_W];
        end
      end
      if (hit) begin
        taken[best]   = 1'b1;
        pick_vld_o[k] = 1'b1;
        pick_tid_o[k*TID_W +: TID_W] = TID_W'(best);
      end
    end
  end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SLOTS       = 2,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   policy_i,
  input  logic [NUM_THREADS*ST_W-1:0]  thr_state_i,
  input  logic [NUM_THREADS-1:0]       thr_active_i,
  input  logic [NUM_THREADS*CNT_W-1:0] iq_cnt_i,
  input  logic [NUM_THREADS*CNT_W-1:0] lsq_cnt_i,
  output logic [SLOTS-1:0]             grant_vld_o,
  output logic [SLOTS*TID_W-1:0]       grant_tid_o
);

  localparam bit MULTI = (NUM_THREADS > 1);

  sel_pol_e                     pol;
  logic                         use_rr;
  logic                         force_t0;
  logic [NUM_THREADS-1:0]       elig;
  logic [NUM_THREADS*CNT_W-1:0] cnt_sel;
  logic [SLOTS-1:0]             rr_vld, occ_vld;
  logic [SLOTS*TID_W-1:0]       rr_tid, occ_tid;

  assign pol      = sel_pol_e'(policy_i);
  assign force_t0 = MULTI && (pol == POL_SINGLE);
  // a single-thread build serves thread 0 on eligibility alone, via the list picker
  assign use_rr   = (pol == POL_RR) || (!MULTI && (pol == POL_SINGLE));
  assign cnt_sel  = (pol == POL_LSQ) ? lsq_cnt_i : iq_cnt_i;

  fsel_elig #(.N(NUM_THREADS)) u_elig (
    .state_i  (thr_state_i),
    .active_i (thr_active_i),
    .elig_o   (elig)
  );

  fsel_rr #(.N(NUM_THREADS), .SLOTS(SLOTS), .TID_W(TID_W)) u_rr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_en_i   (use_rr),
    .elig_i     (elig),
    .pick_vld_o (rr_vld),
    .pick_tid_o (rr_tid)
  );

  fsel_occ #(.N(NUM_THREADS), .SLOTS(SLOTS), .CNT_W(CNT_W), .TID_W(TID_W)) u_occ (
    .elig_i     (elig),
    .cnt_i      (cnt_sel),
    .pick_vld_o (occ_vld),
    .pick_tid_o (occ_tid)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      if (force_t0) begin
        grant_vld_o[k] = (k == 0);
        grant_tid_o[k*TID_W +: TID_W] = '0;
      end else if (use_rr) begin
        grant_vld_o[k] = rr_vld[k];
        grant_tid_o[k*TID_W +: TID_W] = rr_tid[k*TID_W +: TID_W];
      end else begin
        grant_vld_o[k] = occ_vld[k];
        grant_tid_o[k*TID_W +: TID_W] = occ_tid[k*TID_W +: TID_W];
      end
    end
  end

endmodule

// File: rtl/fsel_chk.sv
module fsel_chk
  import fsel_pkg::*;
#(
  parameter int N     = 4,
  parameter int SLOTS = 2,
  parameter int CNT_W = 6,
  parameter int TID_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             policy_i,
  input logic [N*ST_W-1:0]      thr_state_i,
  input logic [N-1:0]           thr_active_i,
  input logic [N*CNT_W-1:0]     iq_cnt_i,
  input logic [N*CNT_W-1:0]     lsq_cnt_i,
  input logic [SLOTS-1:0]       grant_vld_o,
  input logic [SLOTS*TID_W-1:0] grant_tid_o
);

  localparam bit MULTI = (N > 1);

  logic [SLOTS-1:0] bad_elig;
  logic             bad_min;
  logic             occ_pol;

  assign occ_pol = (policy_i == POL_IQ) || (policy_i == POL_LSQ);

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      bad_elig[k] = 1'b0;
      if (grant_vld_o[k] && !(MULTI && policy_i == POL_SINGLE)) begin
        for (int j = 0; j < N; j++) begin
          if (grant_tid_o[k*TID_W +: TID_W] == TID_W'(j) &&
              !(thr_active_i[j] && st_fetchable(thr_state_i[j*ST_W +: ST_W])))
            bad_elig[k] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] wc;
    wc      = '0;
    bad_min = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (grant_tid_o[0 +: TID_W] == TID_W'(j))
        wc = (policy_i == POL_LSQ) ? lsq_cnt_i[j*CNT_W +: CNT_W] : iq_cnt_i[j*CNT_W +: CNT_W];
    end
    if (MULTI && occ_pol && grant_vld_o[0]) begin
      for (int j = 0; j < N; j++) begin
        if (thr_active_i[j] && st_fetchable(thr_state_i[j*ST_W +: ST_W]) &&
            (((policy_i == POL_LSQ) ? lsq_cnt_i[j*CNT_W +: CNT_W]
                                    : iq_cnt_i[j*CNT_W +: CNT_W]) < wc))
          bad_min = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_k
    p_grant_elig_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bad_elig[k]);
    if (k + 1 < SLOTS) begin : g_pref
      p_no_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_vld_o[k] |-> !grant_vld_o[k+1]);
    end
    for (genvar m = k + 1; m < SLOTS; m++) begin : g_m
      p_distinct_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_vld_o[k] && grant_vld_o[m]) |->
          (grant_tid_o[k*TID_W +: TID_W] != grant_tid_o[m*TID_W +: TID_W]));
    end
  end

  if (MULTI) begin : g_multi
    p_single_t0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == POL_SINGLE) |-> (grant_vld_o[0] && grant_tid_o[0 +: TID_W] == '0
                                    && $countones(grant_vld_o) == 1));
    p_least_occ_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bad_min);
  end else begin : g_one
    p_one_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(grant_vld_o) <= 1);
  end

endmodule

bind fetch_thread_sel fsel_chk #(
  .N(NUM_THREADS), .SLOTS(SLOTS), .CNT_W(CNT_W), .TID_W(TID_W)
) u_fsel_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .thr_state_i  (thr_state_i),
  .thr_active_i (thr_active_i),
  .iq_cnt_i     (iq_cnt_i),
  .lsq_cnt_i    (lsq_cnt_i),
  .grant_vld_o  (grant_vld_o),
  .grant_tid_o  (grant_tid_o)
);

// File: tb/tb_fetch_thread_sel.sv
`timescale 1ns/1ps
module tb_fetch_thread_sel;

  localparam int NT = 4;
  localparam int SL = 2;
  localparam int CW = 6;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]       pol_s;
  logic [NT*3-1:0]  st_s;
  logic [NT-1:0]    act_s;
  logic [NT*CW-1:0] iq_s, lsq_s;
  logic [SL-1:0]    vld;
  logic [SL*TW-1:0] tid;

  fetch_thread_sel #(.NUM_THREADS(NT), .SLOTS(SL), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol_s), .thr_state_i(st_s),
    .thr_active_i(act_s), .iq_cnt_i(iq_s), .lsq_cnt_i(lsq_s),
    .grant_vld_o(vld), .grant_tid_o(tid));

  logic [1:0]    pol1;
  logic [2:0]    st1;
  logic          act1;
  logic [CW-1:0] iq1, lsq1;
  logic [SL-1:0] vld1;
  logic [SL-1:0] tid1;

  fetch_thread_sel #(.NUM_THREADS(1), .SLOTS(SL), .CNT_W(CW)) dut1 (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol1), .thr_state_i(st1),
    .thr_active_i(act1), .iq_cnt_i(iq1), .lsq_cnt_i(lsq1),
    .grant_vld_o(vld1), .grant_tid_o(tid1));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side view of the stimulus
  int m_pol;
  int m_st [NT];
  bit m_act [NT];
  int m_iq [NT];
  int m_lsq [NT];
  int mlist [$];

  typedef struct {
    bit    v [SL];
    int    t [SL];
    string req;
  } exp_t;
  exp_t sb [$];

  function automatic bit ok_thr(int t);
    return m_act[t] && (m_st[t] == 0 || m_st[t] == 1 || m_st[t] == 5);
  endfunction

  function automatic bit in_q(int q [$], int x);
    foreach (q[i]) if (q[i] == x) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    mlist.delete();
    for (int i = 0; i < NT; i++) mlist.push_back(i);
  endtask

  task automatic apply(string req);
    exp_t e;
    int chosen [$];
    @(negedge clk);
    pol_s = m_pol[1:0];
    for (int t = 0; t < NT; t++) begin
      st_s[t*3 +: 3]   = m_st[t][2:0];
      act_s[t]         = m_act[t];
      iq_s[t*CW +: CW] = m_iq[t][CW-1:0];
      lsq_s[t*CW +: CW] = m_lsq[t][CW-1:0];
    end
    e.req = req;
    for (int k = 0; k < SL; k++) begin e.v[k] = 0; e.t[k] = 0; end
    if (m_pol == 0) begin
      e.v[0] = 1; e.t[0] = 0;
    end else if (m_pol == 1) begin
      for (int k = 0; k < SL; k++) begin
        for (int i = 0; i < mlist.size(); i++) begin
          int th;
          th = mlist[i];
          if (ok_thr(th) && !in_q(chosen, th)) begin
            e.v[k] = 1; e.t[k] = th;
            chosen.push_back(th);
            mlist.delete(i);
            mlist.push_back(th);
            break;
          end
        end
      end
    end else begin
      for (int k = 0; k < SL; k++) begin
        int best;
        best = -1;
        for (int th = 0; th < NT; th++) begin
          int c, cb;
          c  = (m_pol == 3) ? m_lsq[th] : m_iq[th];
          cb = (best < 0) ? 0 : ((m_pol == 3) ? m_lsq[best] : m_iq[best]);
          if (ok_thr(th) && !in_q(chosen, th) && (best < 0 || c < cb)) best = th;
        end
        if (best >= 0) begin
          e.v[k] = 1; e.t[k] = best; chosen.push_back(best);
        end
      end
    end
    sb.push_back(e);
  endtask

  // monitor: compare late in the low phase of the clock
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        for (int k = 0; k < SL; k++) begin
          int at;
          at = int'(tid[k*TW +: TW]);
          checks++;
          if (vld[k] !== e.v[k] || (e.v[k] && at != e.t[k])) begin
            errors++;
            $display("FAIL %s slot%0d: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
                     e.req, k, vld[k], at, e.v[k], e.t[k]);
          end
        end
      end
    end
  end

  task automatic set_all(int st, bit a);
    for (int t = 0; t < NT; t++) begin m_st[t] = st; m_act[t] = a; m_iq[t] = 0; m_lsq[t] = 0; end
  endtask

  task automatic chk1(int p, int st, bit a, bit ev, string req);
    @(negedge clk);
    pol1 = p[1:0]; st1 = st[2:0]; act1 = a;
    #3;
    checks++;
    if (vld1 !== {1'b0, ev} || (ev && tid1[0] !== 1'b0)) begin
      errors++;
      $display("FAIL %s one-thread: got vld=%b tid0=%0b, expected vld=%b tid0=0",
               req, vld1, tid1[0], {1'b0, ev});
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      finish_run();
    end
  end

  initial begin
    pol_s = 2'd1; st_s = '0; act_s = '0; iq_s = '0; lsq_s = '0;
    pol1 = 2'd0; st1 = 3'd3; act1 = 1'b0; iq1 = '0; lsq1 = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: list starts 0,1,2,3
    m_pol = 1; set_all(0, 1); apply("R5 reset order");
    // R3 R4: rotated list now 2,3,0,1
    apply("R3 R4 rotation");
    // R1: only states 1 and 5 eligible here
    m_st[0] = 2; m_st[1] = 5; m_st[2] = 3; m_st[3] = 1; apply("R1 state codes");
    // R1: active mask filters
    set_all(0, 1); m_act[0] = 0; m_act[2] = 0; apply("R1 active mask");
    // R8: nothing eligible
    set_all(4, 1); apply("R8 none eligible");
    // R8: one eligible fills slot 0 only
    set_all(6, 1); m_st[2] = 0; apply("R8 single eligible");
    // R2: thread 0 forced regardless of eligibility
    m_pol = 0; set_all(7, 0); apply("R2 single-thread policy");
    // R4: list untouched by the single-thread cycle
    m_pol = 1; set_all(1, 1); apply("R4 list hold after single");
    // R6: issue-queue ranking with tie
    m_pol = 2; set_all(0, 1);
    m_iq[0] = 5; m_iq[1] = 2; m_iq[2] = 2; m_iq[3] = 9;
    m_lsq[0] = 0; m_lsq[3] = 0; apply("R6 iq tie to lower index");
    // R6: load/store-queue counts used under code 3
    m_pol = 3; m_lsq[0] = 1; m_lsq[1] = 7; m_lsq[2] = 0; m_lsq[3] = 3; apply("R6 lsq ranking");
    // R6 R1: ineligible low-count thread skipped
    m_pol = 2; m_st[1] = 3; apply("R6 R1 skip ineligible");
    // R7: one eligible thread not repeated
    m_pol = 2; set_all(3, 1); m_st[3] = 5; apply("R7 no repeat");
    // R4: occupancy cycles left the list alone
    m_pol = 1; set_all(0, 1); apply("R4 list hold after occupancy");

    // mixed random traffic against the model
    for (int n = 0; n < 400; n++) begin
      m_pol = $urandom_range(0, 3);
      for (int t = 0; t < NT; t++) begin
        m_st[t]  = $urandom_range(0, 7);
        m_act[t] = ($urandom_range(0, 3) != 0);
        m_iq[t]  = $urandom_range(0, 7);
        m_lsq[t] = $urandom_range(0, 7);
      end
      apply("R3 R4 R6 R7 mixed");
    end

    // R5: reset in mid-run restores order
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    m_pol = 1; set_all(0, 1); apply("R5 second reset");
    repeat (3) @(negedge clk);

    // R9: one-thread build ignores the policy code
    chk1(0, 0, 1, 1, "R9 single policy running");
    chk1(0, 3, 1, 0, "R9 single policy blocked");
    chk1(1, 5, 0, 0, "R9 inactive");
    chk1(2, 1, 1, 1, "R9 iq policy idle");
    chk1(3, 4, 1, 0, "R9 lsq policy waiting");
    chk1(1, 5, 1, 1, "R9 rr policy done");

    done = 1;
    finish_run();
  end

endmodule